// File: doc/BRIEF.md
# Banked Nonvolatile Array Controller with SECDED

This block models a small nonvolatile store split into independent banks, each kept in on-chip registers. A command port takes an operation code, a byte address and a 64-bit data phrase, and runs phrase programming, phrase erase and whole-bank erase. Each command holds the controller busy for a fixed number of cycles. Programming works on whole phrases, and a phrase must be in the erased state before it is programmed.

Every stored 64-bit phrase carries an 8-bit check code: seven Hamming bits and one overall parity bit. The code is biased so that a fully erased phrase (all 72 stored bits at 1) decodes as valid data with no error. A read port serves byte, aligned-word and misaligned-word requests through a valid/ready handshake. The response carries the corrected data and two flags: one for a single-bit correction and one for a double-bit detection. A test-only fault input XORs a chosen mask into a stored phrase, so that the correction and detection paths can be exercised.

The read request obeys valid/ready rules. A request transfers on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high, the requester holds `rd_addr` and `rd_word` stable. `rd_ready` depends on the offered address, because a request is stalled only when it touches the bank that is currently busy. The response channel has no back-pressure: the requester must take `rsp_valid` in the cycle it appears.

Top module: `nvm_bank_ctrl`

## Requirements
- R1: A legal command written with `cmd_wr` while idle raises `cmd_busy` for exactly BUSY_CYCLES cycles, starting after the accepting edge. Its effect on the array is visible from the first cycle in which `cmd_busy` is low again.
- R2: A `cmd_wr` while `cmd_busy` is high is refused: `status` bit 0 (access error) is set and the array is left unchanged.
- R3: The operation codes are 2'b01 program, 2'b10 erase phrase and 2'b11 erase bank. Code 2'b00 is refused with `status` bit 0. A program whose address has bits [2:0] not zero is refused with `status` bit 0 and does not start. A legal program stores the phrase given on `cmd_data`.
- R4: A program aimed at a phrase whose 72 stored bits are not all 1 is refused, sets `status` bit 1 and leaves the phrase unchanged.
- R5: Erased storage reads as all ones (each byte 8'hFF). Erase phrase restores one phrase, ignoring address bits [2:0]. Erase bank restores every phrase of the addressed bank.
- R6: While a command runs, `rd_ready` is low for a request that touches the busy bank. For a misaligned word this includes the bank of its second byte. A request to any other bank is accepted and answered during the command.
- R7: A byte read or an even-address word read answers with `rsp_valid` in the cycle after acceptance. An odd-address word read answers two cycles after acceptance, with `rd_ready` low and no response in between. A byte read returns {8'h00, byte}. A word at address A returns {byte A, byte A+1}, the byte address wrapping at the top of the space.
- R8: In byte addressing, byte offset k of a phrase is phrase bits [63-8k:56-8k]. The fault mask's bits [63:0] hit the data and bits [71:64] hit the check code. With one stored bit flipped, the read returns the original data with `rsp_sbc`=1 and `rsp_dbd`=0. With two bits flipped, it returns `rsp_dbd`=1 and `rsp_sbc`=0.
- R9: The `status` bits are sticky: bit 0 access error, bit 1 overwrite refused, bit 2 corrected read, bit 3 uncorrectable read. Writing 1 to a bit of `status_clr` clears it, and a new set in the same cycle takes priority.
- R10: The address splits into bank = addr[10:9], phrase index = addr[8:3] and byte offset = addr[2:0], giving 4 banks of 64 phrases each. Phrases at different addresses are stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the array is set to the erased state |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 11 | Command byte address |
| cmd_data | input | 64 | Phrase to program |
| cmd_busy | output | 1 | Command executing |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle if valid |
| rd_addr | input | 11 | Read byte address |
| rd_word | input | 1 | 1 selects a word, 0 selects a byte |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | 16 | Read data |
| rsp_sbc | output | 1 | A single-bit fault was corrected |
| rsp_dbd | output | 1 | A double-bit fault was detected |
| status | output | 4 | Sticky error and ECC flags |
| status_clr | input | 4 | Write-1-to-clear mask for the status bits |
| fi_wr | input | 1 | Test-only fault injection strobe |
| fi_phrase | input | 8 | Global phrase index (bank and phrase) for the injection |
| fi_mask | input | 72 | Bits to flip in the stored phrase |

## Verification
The assertions assume that `rd_addr` and `rd_word` stay stable while `rd_valid` is high, because `rd_ready` is judged on the offered address. They also assume that `status_clr` is only pulsed when no new flag is expected in the same cycle. The stimulus drives every input on the falling clock edge and removes `rd_valid` right after acceptance. It pulses `status_clr` only between transactions, and it injects faults only while no read or command touches the phrase concerned. Because of this, the handshake and sticky-flag properties see only input behaviour that the requester is allowed to produce.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_ERPH = 2'b10,
    OP_ERBK = 2'b11
  } nvm_op_e;

  typedef struct packed {
    logic [63:0] data;
    logic        sbc;
    logic        dbd;
  } ecc_res_t;

  // Plain extended Hamming check bits: [6:0] position parities, [7] overall parity.
  function automatic logic [7:0] ecc_raw(input logic [63:0] d);
    logic [6:0] p;
    int k;
    p = '0;
    k = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int j = 0; j < 7; j++)
          if (((pos >> j) & 1) == 1) p[j] = p[j] ^ d[k];
        k++;
      end
    end
    return {(^d) ^ (^p), p};
  endfunction

  // Bias so that all-ones data carries all-ones check bits.
  localparam logic [7:0] ECC_FIX = ecc_raw({64{1'b1}}) ^ 8'hFF;

  function automatic logic [71:0] ecc_encode(input logic [63:0] d);
    return {ecc_raw(d) ^ ECC_FIX, d};
  endfunction

  function automatic ecc_res_t ecc_decode(input logic [71:0] cw);
    logic [7:0]  chk;
    logic [71:0] code;
    logic [6:0]  syn;
    logic        ovr;
    int k, pi;
    ecc_res_t r;
    chk = cw[71:64] ^ ECC_FIX;
    code = '0;
    code[0] = chk[7];
    k = 0;
    pi = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) == 0) begin
        code[pos] = chk[pi];
        pi++;
      end else begin
        code[pos] = cw[k];
        k++;
      end
    end
    syn = '0;
    for (int pos = 1; pos < 72; pos++)
      for (int j = 0; j < 7; j++)
        if (((pos >> j) & 1) == 1) syn[j] = syn[j] ^ code[pos];
    ovr = ^code;
    r.sbc = 1'b0;
    r.dbd = 1'b0;
    if (ovr) begin
      if (int'(syn) < 72) begin
        code[syn] = ~code[syn];
        r.sbc = 1'b1;
      end else begin
        r.dbd = 1'b1;
      end
    end else if (syn != 7'd0) begin
      r.dbd = 1'b1;
    end
    k = 0;
    r.data = '0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        r.data[k] = code[pos];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/nvm_bank.sv
module nvm_bank #(
  parameter int PHRASES = 64,
  localparam int IDX_W = $clog2(PHRASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [71:0]      wr_word,
  input  logic             clr_all,
  input  logic             fi_en,
  input  logic [IDX_W-1:0] fi_idx,
  input  logic [71:0]      fi_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [71:0]      rd_word,
  input  logic [IDX_W-1:0] pk_idx,
  output logic [71:0]      pk_word
);

  logic [71:0] mem [PHRASES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHRASES; i++) mem[i] <= '1;
    end else if (clr_all) begin
      for (int i = 0; i < PHRASES; i++) mem[i] <= '1;
    end else begin
      if (fi_en) mem[fi_idx] <= mem[fi_idx] ^ fi_mask;
      if (wr_en) mem[wr_idx] <= wr_word;
    end
  end

  assign rd_word = mem[rd_idx];
  assign pk_word = mem[pk_idx];

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BUSY_CYCLES = 6,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [63:0]       cmd_data,
  input  logic              tgt_erased,
  output logic              busy,
  output nvm_op_e           op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [63:0]       data_q,
  output logic              commit,
  output logic              acc_err,
  output logic              pgm_err
);

  logic [CNT_W-1:0] cnt;
  nvm_op_e op_in;
  logic misal, start;

  assign op_in   = nvm_op_e'(cmd_op);
  assign busy    = (cnt != '0);
  assign commit  = (cnt == CNT_W'(1));
  assign misal   = (op_in == OP_PROG) && (cmd_addr[2:0] != 3'd0);
  assign acc_err = cmd_wr && (busy || op_in == OP_NONE || misal);
  assign pgm_err = cmd_wr && !busy && (op_in == OP_PROG) && !misal && !tgt_erased;
  assign start   = cmd_wr && !acc_err && !pgm_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      cnt    <= CNT_W'(BUSY_CYCLES);
      op_q   <= op_in;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/nvm_rd_port.sv
module nvm_rd_port
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_word,
  output logic              rd_ready,
  input  logic              busy,
  input  logic [BANK_W-1:0] busy_bank,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [71:0]       fetch_word,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic              rsp_sbc,
  output logic              rsp_dbd
);

  logic              second, miss, blocked, acc;
  logic [ADDR_W-1:0] addr_q, rd_nxt;
  logic [7:0]        hi_q, b_at, b_nx;
  logic              sbc_q, dbd_q;
  logic [2:0]        off;
  ecc_res_t          dec;

  assign miss    = rd_word && rd_addr[0];
  assign rd_nxt  = rd_addr + 1'b1;
  assign blocked = busy && ((rd_addr[ADDR_W-1 -: BANK_W] == busy_bank) ||
                            (miss && rd_nxt[ADDR_W-1 -: BANK_W] == busy_bank));
  assign rd_ready   = !second && !blocked;
  assign acc        = rd_valid && rd_ready;
  assign fetch_addr = second ? addr_q + 1'b1 : rd_addr;

  assign dec  = ecc_decode(fetch_word);
  assign off  = fetch_addr[2:0];
  assign b_at = 8'(dec.data >> {3'd7 - off, 3'b000});
  assign b_nx = 8'(dec.data >> {3'd7 - (off | 3'd1), 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second    <= 1'b0;
      addr_q    <= '0;
      hi_q      <= '0;
      sbc_q     <= 1'b0;
      dbd_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_sbc   <= 1'b0;
      rsp_dbd   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (second) begin
        second    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= {hi_q, b_at};
        rsp_sbc   <= sbc_q | dec.sbc;
        rsp_dbd   <= dbd_q | dec.dbd;
      end else if (acc && miss) begin
        second <= 1'b1;
        addr_q <= rd_addr;
        hi_q   <= b_at;
        sbc_q  <= dec.sbc;
        dbd_q  <= dec.dbd;
      end else if (acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_word ? {b_at, b_nx} : {8'h00, b_at};
        rsp_sbc   <= dec.sbc;
        rsp_dbd   <= dec.dbd;
      end
    end
  end

endmodule

// File: rtl/nvm_bank_ctrl.sv
module nvm_bank_ctrl
  import nvm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int PHRASES = 64,
  parameter int BUSY_CYCLES = 6,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W = $clog2(PHRASES),
  localparam int PH_W = BANK_W + IDX_W,
  localparam int ADDR_W = PH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [63:0]       cmd_data,
  output logic              cmd_busy,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_word,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic              rsp_sbc,
  output logic              rsp_dbd,
  output logic [3:0]        status,
  input  logic [3:0]        status_clr,
  input  logic              fi_wr,
  input  logic [PH_W-1:0]   fi_phrase,
  input  logic [71:0]       fi_mask
);

  nvm_op_e           op_q;
  logic [ADDR_W-1:0] addr_q, fetch_addr;
  logic [63:0]       data_q;
  logic              commit, acc_err, pgm_err, tgt_erased;
  logic [BANK_W-1:0] busy_bank;
  logic [71:0]       commit_word;
  logic [71:0]       rd_word_b [NUM_BANKS];
  logic [71:0]       pk_word_b [NUM_BANKS];
  logic [3:0]        st_set;

  assign busy_bank   = addr_q[ADDR_W-1 -: BANK_W];
  assign commit_word = (op_q == OP_PROG) ? ecc_encode(data_q) : '1;
  assign tgt_erased  = &pk_word_b[cmd_addr[ADDR_W-1 -: BANK_W]];

  nvm_cmd_seq #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .tgt_erased(tgt_erased),
    .busy(cmd_busy), .op_q(op_q), .addr_q(addr_q), .data_q(data_q),
    .commit(commit), .acc_err(acc_err), .pgm_err(pgm_err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (busy_bank == BANK_W'(b));
    nvm_bank #(.PHRASES(PHRASES)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && sel && (op_q == OP_PROG || op_q == OP_ERPH)),
      .wr_idx(addr_q[IDX_W+2:3]), .wr_word(commit_word),
      .clr_all(commit && sel && op_q == OP_ERBK),
      .fi_en(fi_wr && fi_phrase[PH_W-1 -: BANK_W] == BANK_W'(b)),
      .fi_idx(fi_phrase[IDX_W-1:0]), .fi_mask(fi_mask),
      .rd_idx(fetch_addr[IDX_W+2:3]), .rd_word(rd_word_b[b]),
      .pk_idx(cmd_addr[IDX_W+2:3]), .pk_word(pk_word_b[b])
    );
  end

  nvm_rd_port #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_word(rd_word), .rd_ready(rd_ready), .busy(cmd_busy),
    .busy_bank(busy_bank), .fetch_addr(fetch_addr),
    .fetch_word(rd_word_b[fetch_addr[ADDR_W-1 -: BANK_W]]),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_sbc(rsp_sbc),
    .rsp_dbd(rsp_dbd)
  );

  assign st_set = {rsp_valid & rsp_dbd, rsp_valid & rsp_sbc, pgm_err, acc_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~status_clr) | st_set;
  end

endmodule

// File: rtl/nvm_bank_ctrl_chk.sv
module nvm_bank_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              cmd_busy,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_word,
  input logic              rsp_valid,
  input logic [15:0]       rsp_data,
  input logic              rsp_sbc,
  input logic              rsp_dbd,
  input logic [3:0]        status,
  input logic [3:0]        status_clr,
  input logic [BANK_W-1:0] busy_bank
);

  a_r1_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> $past(cmd_wr));

  a_r2_reject_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_busy |=> status[0]);

  a_r6_busy_bank_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy && rd_valid && rd_ready |-> rd_addr[ADDR_W-1 -: BANK_W] != busy_bank);

  a_r7_short_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !(rd_word && rd_addr[0]) |=> rsp_valid);

  a_r7_split_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_word && rd_addr[0] |=> !rsp_valid && !rd_ready ##1 rsp_valid);

  a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !rd_word |=> rsp_data[15:8] == 8'h00);

  a_r9_sbc_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_sbc |=> status[2]);

  a_r9_dbd_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_dbd |=> status[3]);

  a_r9_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] && !status_clr[3] |=> status[3]);

endmodule

bind nvm_bank_ctrl nvm_bank_ctrl_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_busy(cmd_busy),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rd_word(rd_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_sbc(rsp_sbc), .rsp_dbd(rsp_dbd), .status(status),
  .status_clr(status_clr), .busy_bank(busy_bank)
);

// File: tb/nvm_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvm_bank_ctrl_tb_top;

  localparam int BUSY = 6;
  localparam logic [1:0] C_PROG = 2'b01, C_ERPH = 2'b10, C_ERBK = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic cmd_busy, rd_ready, rsp_valid, rsp_sbc, rsp_dbd;
  logic rd_valid = 1'b0;
  logic [10:0] rd_addr = '0;
  logic rd_word = 1'b0;
  logic [15:0] rsp_data;
  logic [3:0] status;
  logic [3:0] status_clr = '0;
  logic fi_wr = 1'b0;
  logic [7:0] fi_phrase = '0;
  logic [71:0] fi_mask = '0;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] model [256];

  always #10 clk = ~clk;

  nvm_bank_ctrl #(.NUM_BANKS(4), .PHRASES(64), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_busy(cmd_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_word(rd_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_sbc(rsp_sbc), .rsp_dbd(rsp_dbd), .status(status),
    .status_clr(status_clr), .fi_wr(fi_wr), .fi_phrase(fi_phrase),
    .fi_mask(fi_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int g);
    logic [63:0] v;
    v = {8{8'(g)}} ^ 64'h0F1E_2D3C_4B5A_6978;
    return v ^ (64'(g) << (g % 53));
  endfunction

  function automatic logic [7:0] eb(input logic [10:0] a);
    return 8'(model[a[10:3]] >> (8 * (7 - int'(a[2:0]))));
  endfunction

  function automatic logic [15:0] ew(input logic [10:0] a, input logic w);
    return w ? {eb(a), eb(11'(a + 1))} : {8'h00, eb(a)};
  endfunction

  task automatic issue(input logic [1:0] op, input logic [10:0] a, input logic [63:0] d);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (cmd_busy) @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] a, input logic w, input logic [15:0] exp,
                    input logic esbc, input logic edbd, input bit cd, input string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_word = w;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rd_valid = 1'b0;
    if (w && a[0]) begin
      chk(!rsp_valid && !rd_ready, {req, " split read gap"}, {rsp_valid, rd_ready}, 0);
      @(negedge clk);
    end
    if (cd)
      chk({rsp_valid, rsp_data, rsp_sbc, rsp_dbd} === {1'b1, exp, esbc, edbd}, req,
          {rsp_valid, rsp_data, rsp_sbc, rsp_dbd}, {1'b1, exp, esbc, edbd});
    else
      chk({rsp_valid, rsp_sbc, rsp_dbd} === {1'b1, esbc, edbd}, req,
          {rsp_valid, rsp_sbc, rsp_dbd}, {1'b1, esbc, edbd});
  endtask

  task automatic inject(input logic [7:0] g, input logic [71:0] m);
    @(negedge clk);
    fi_wr = 1'b1; fi_phrase = g; fi_mask = m;
    @(negedge clk);
    fi_wr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); status_clr = 4'hF;
    @(negedge clk); status_clr = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog requirement=any act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk({cmd_busy, rsp_valid, status, rd_ready} === 7'b0000001, "R1 reset state",
        {cmd_busy, rsp_valid, status, rd_ready}, 7'b0000001);

    // R5 R10: erased space reads all ones everywhere
    for (int a = 0; a < 2048; a++) rd(11'(a), 1'b0, 16'h00FF, 0, 0, 1, "R5 erased byte");

    // R1: busy length on the first program
    issue(C_PROG, 11'd0, pat(0));
    n = 0;
    while (cmd_busy) begin n++; @(negedge clk); end
    chk(n == BUSY, "R1 busy length", n, BUSY);
    model[0] = pat(0);
    // R10: program every phrase with a distinct pattern
    for (int g = 1; g < 256; g++) begin
      issue(C_PROG, 11'(g << 3), pat(g));
      wait_idle();
      model[g] = pat(g);
    end
    // R3 R7 R10: full readback sweeps
    for (int a = 0; a < 2048; a++) rd(11'(a), 1'b0, ew(11'(a), 0), 0, 0, 1, "R10 byte sweep");
    for (int a = 0; a < 2048; a += 2) rd(11'(a), 1'b1, ew(11'(a), 1), 0, 0, 1, "R7 aligned word");
    for (int a = 1; a < 2048; a += 2) rd(11'(a), 1'b1, ew(11'(a), 1), 0, 0, 1, "R7 misaligned word");
    chk(status === 4'h0, "R9 no flags after clean traffic", status, 0);

    // R6: erase bank 1 while reading elsewhere
    issue(C_ERBK, 11'h200, '0);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 11'h210; rd_word = 1'b0; #1;
    chk(rd_ready === 1'b0, "R6 busy bank byte stalls", rd_ready, 0);
    rd_addr = 11'h1FF; rd_word = 1'b1; #1;
    chk(rd_ready === 1'b0, "R6 word spilling into busy bank stalls", rd_ready, 0);
    rd_valid = 1'b0;
    rd(11'h404, 1'b0, ew(11'h404, 0), 0, 0, 1, "R6 other bank served");
    chk(cmd_busy === 1'b1, "R6 served during command", cmd_busy, 1);
    wait_idle();
    for (int g = 64; g < 128; g++) model[g] = '1;
    rd(11'h210, 1'b1, 16'hFFFF, 0, 0, 1, "R5 bank erased");
    rd(11'h3FF, 1'b0, 16'h00FF, 0, 0, 1, "R5 bank erased last byte");
    rd(11'h1FF, 1'b1, ew(11'h1FF, 1), 0, 0, 1, "R7 word across bank edge");

    // R4: overwrite of programmed phrase refused
    issue(C_PROG, 11'(5 << 3), 64'h0);
    chk({status[1], cmd_busy} === 2'b10, "R4 overwrite refused", {status[1], cmd_busy}, 2'b10);
    rd(11'(5 << 3), 1'b1, ew(11'(5 << 3), 1), 0, 0, 1, "R4 phrase unchanged");
    // R3: misaligned program and illegal op
    clear_status();
    chk(status === 4'h0, "R9 write-1 clear", status, 0);
    issue(C_PROG, 11'((64 << 3) | 3), 64'h1234);
    chk({status[0], cmd_busy} === 2'b10, "R3 misaligned program refused", {status[0], cmd_busy}, 2'b10);
    rd(11'((64 << 3) | 3), 1'b0, 16'h00FF, 0, 0, 1, "R3 misaligned program no write");
    clear_status();
    issue(2'b00, 11'(70 << 3), 64'h0);
    chk({status[0], cmd_busy} === 2'b10, "R3 code 00 refused", {status[0], cmd_busy}, 2'b10);
    clear_status();
    issue(C_PROG, 11'(64 << 3), 64'hDEAD_BEEF_0BAD_F00D);
    wait_idle();
    model[64] = 64'hDEAD_BEEF_0BAD_F00D;
    rd(11'(64 << 3), 1'b1, 16'hDEAD, 0, 0, 1, "R3 program after erase");
    rd(11'((64 << 3) | 7), 1'b0, 16'h000D, 0, 0, 1, "R3 program last byte");
    chk(status === 4'h0, "R3 legal program no flag", status, 0);

    // R5: erase one phrase, offset bits ignored
    issue(C_ERPH, 11'((6 << 3) | 5), '0);
    wait_idle();
    model[6] = '1;
    rd(11'(6 << 3), 1'b1, 16'hFFFF, 0, 0, 1, "R5 phrase erased");
    rd(11'(7 << 3), 1'b1, ew(11'(7 << 3), 1), 0, 0, 1, "R5 neighbour kept");

    // R2: command while busy refused, bank 3 untouched
    issue(C_ERPH, 11'(9 << 3), '0);
    issue(C_ERBK, 11'h600, '0);
    wait_idle();
    model[9] = '1;
    chk(status[0] === 1'b1, "R2 busy write flagged", status, 1);
    rd(11'(200 << 3), 1'b1, ew(11'(200 << 3), 1), 0, 0, 1, "R2 bank 3 untouched");
    rd(11'(9 << 3), 1'b0, 16'h00FF, 0, 0, 1, "R2 running command completed");
    clear_status();

    // R8: every single-bit flip is corrected
    for (int b = 0; b < 72; b++) begin
      inject(8'd200, 72'(1) << b);
      rd(11'((200 << 3) + 2 * (b % 4)), 1'b1, ew(11'((200 << 3) + 2 * (b % 4)), 1), 1, 0, 1, "R8 single flip");
      inject(8'd200, 72'(1) << b);
    end
    // R8: adjacent double flips detected
    for (int b = 0; b < 72; b++) begin
      inject(8'd201, (72'(1) << b) | (72'(1) << ((b + 1) % 72)));
      rd(11'(201 << 3), 1'b0, 16'h0, 0, 1, 0, "R8 double flip");
      inject(8'd201, (72'(1) << b) | (72'(1) << ((b + 1) % 72)));
    end
    // R8: erased phrase with a check-bit flip
    inject(8'd100, 72'(1) << 70);
    rd(11'(100 << 3), 1'b1, 16'hFFFF, 1, 0, 1, "R8 erased phrase corrected");
    inject(8'd100, 72'(1) << 70);
    rd(11'(200 << 3), 1'b1, ew(11'(200 << 3), 1), 0, 0, 1, "R8 phrase restored");
    chk(status[3:2] === 2'b11, "R9 ECC flags sticky", status, 4'hC);
    clear_status();
    chk(status === 4'h0, "R9 clear ECC flags", status, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule